// File: doc/BRIEF.md
# Reset Stretcher with Serial-Output Safe State

This block sits between the board-level reset pin and the rest of a serial stream switch. A low level on the external reset pin drops the internal reset at once, with no clock needed. The release of the pin is brought into the clock domain through a short synchroniser. The internal reset is then held for a settling interval, computed from the clock frequency and a time in microseconds, so that a clock multiplier has time to lock before any core logic runs.

The same block decides what the serial stream pins show. The local and backplane stream groups are each presented as a value vector plus an output-enable vector. The core's data reaches the pins only when the internal reset is released and the drive-enable pin is high. Otherwise each group takes a safe state picked by its own strap input: driven high, or high impedance. In the safe state the buffer-control outputs that steer external line drivers are held low. Every pin is a plain control or data level. No stream handshake is involved, so nothing can be held back.

Top module: `rst_stretch_safe_ctl`

## Requirements
- R1: A low level on `rst_pin_n` drives `core_rst_n` low without waiting for a clock edge, and holds it low while the pin stays low.
- R2: When `rst_pin_n` rises between clock edges, `core_rst_n` first reads high after rising clock edge number SYNC_DEPTH + STRETCH_CYC counted from that rise. STRETCH_CYC = ceil(CLK_KHZ * SETTLE_US / 1000), which is 400 with the defaults, so the release falls on edge 402.
- R3: A new low level on the pin while the settling interval is running restarts the whole interval. The release after it again takes the full count of R2.
- R4: A low pulse that covers two rising clock edges produces the full stretched reset of R2.
- R5: Once `core_rst_n` is high, it stays high for as long as `rst_pin_n` stays high.
- R6: The block is in the safe state whenever `core_rst_n` is low or `drive_en` is low. In the safe state no core data reaches the stream outputs.
- R7: In the safe state with `loc_strap_hi`=1, every bit of `loc_out` and `loc_oe` is 1. With `loc_strap_hi`=0, every bit of `loc_oe` is 0 (high impedance) and `loc_out` reads 0.
- R8: The backplane group (`bp_out`, `bp_oe`) follows `bp_strap_hi` by the same rule as R7, independently of the local strap.
- R9: In the safe state `loc_bufctl` and `bp_bufctl` are all zeros.
- R10: Outside the safe state, `loc_out`/`bp_out` equal the core data inputs, every `loc_oe`/`bp_oe` bit is 1, and the buffer-control outputs equal their core inputs.
- R11: A change of `drive_en` reaches the stream and buffer-control outputs within the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, about 8 MHz |
| rst_pin_n | input | 1 | External reset, active low, asynchronous |
| drive_en | input | 1 | Output drive enable; low forces the safe state |
| loc_strap_hi | input | 1 | Local group safe state: 1 drive high, 0 high impedance |
| bp_strap_hi | input | 1 | Backplane group safe state: 1 drive high, 0 high impedance |
| loc_data_in | input | LOC_N | Local stream bits from the core |
| bp_data_in | input | BP_N | Backplane stream bits from the core |
| loc_bufctl_in | input | LOC_CW | Local buffer-control levels from the core |
| bp_bufctl_in | input | BP_CW | Backplane buffer-control levels from the core |
| core_rst_n | output | 1 | Stretched internal reset, active low |
| loc_out | output | LOC_N | Local stream pin values |
| loc_oe | output | LOC_N | Local stream output enables, 1 = driving |
| bp_out | output | BP_N | Backplane stream pin values |
| bp_oe | output | BP_N | Backplane stream output enables, 1 = driving |
| loc_bufctl | output | LOC_CW | Local external-buffer controls |
| bp_bufctl | output | BP_CW | Backplane external-buffer controls |

## Verification
A stuck or miscounted stretch counter shows at the ports as `core_rst_n` rising on the wrong edge. The bench counts edges from each pin release and compares the first high edge against the exact expected number, so an error of a single cycle is caught at release time. A counter or synchroniser that fails to clear on a short or mid-interval pulse shows up as an early release after that pulse. The output mux state is combinational, so a wrong strap or enable decode is visible in the same cycle as the stimulus. The bench samples it a few nanoseconds after each input change.

// File: rtl/rst_safe_pkg.sv
`timescale 1ns/1ps
package rst_safe_pkg;

  // How a stream group presents its pins.
  typedef enum logic [1:0] {
    OUT_DATA = 2'd0,
    OUT_HIGH = 2'd1,
    OUT_HIZ  = 2'd2
  } out_mode_e;

  // Settling interval in clock cycles, rounded up.
  function automatic int unsigned stretch_cycles(input int unsigned clk_khz,
                                                 input int unsigned settle_us);
    return (clk_khz * settle_us + 999) / 1000;
  endfunction

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic released
);
  logic [DEPTH-1:0] chain_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[DEPTH-2:0], 1'b1};
      end
    end
  endgenerate

  assign released = chain_q[DEPTH-1];
endmodule

// File: rtl/rst_stretch_cnt.sv
`timescale 1ns/1ps
module rst_stretch_cnt #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic arst_n,
  input  logic released,
  output logic done_n
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (released && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_n = done_q;
endmodule

// File: rtl/stream_safe_mux.sv
`timescale 1ns/1ps
module stream_safe_mux
  import rst_safe_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 2
) (
  input  logic          safe,
  input  logic          strap_hi,
  input  logic [W-1:0]  data_in,
  input  logic [CW-1:0] ctl_in,
  output logic [W-1:0]  data_out,
  output logic [W-1:0]  oe,
  output logic [CW-1:0] ctl_out
);
  out_mode_e mode;

  always_comb begin
    if (!safe)         mode = OUT_DATA;
    else if (strap_hi) mode = OUT_HIGH;
    else               mode = OUT_HIZ;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign data_out[b] = (mode == OUT_DATA) ? data_in[b] : (mode == OUT_HIGH);
    assign oe[b]       = (mode != OUT_HIZ);
  end

  assign ctl_out = (mode == OUT_DATA) ? ctl_in : '0;
endmodule

// File: rtl/rst_stretch_safe_ctl.sv
`timescale 1ns/1ps
module rst_stretch_safe_ctl
  import rst_safe_pkg::*;
#(
  parameter int LOC_N      = 16,
  parameter int BP_N       = 32,
  parameter int LOC_CW     = 2,
  parameter int BP_CW      = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int CLK_KHZ    = 8000,
  parameter int SETTLE_US  = 50
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              drive_en,
  input  logic              loc_strap_hi,
  input  logic              bp_strap_hi,
  input  logic [LOC_N-1:0]  loc_data_in,
  input  logic [BP_N-1:0]   bp_data_in,
  input  logic [LOC_CW-1:0] loc_bufctl_in,
  input  logic [BP_CW-1:0]  bp_bufctl_in,
  output logic              core_rst_n,
  output logic [LOC_N-1:0]  loc_out,
  output logic [LOC_N-1:0]  loc_oe,
  output logic [BP_N-1:0]   bp_out,
  output logic [BP_N-1:0]   bp_oe,
  output logic [LOC_CW-1:0] loc_bufctl,
  output logic [BP_CW-1:0]  bp_bufctl
);
  localparam int STRETCH_CYC = int'(stretch_cycles(CLK_KHZ, SETTLE_US));
  localparam int REL_EDGES   = SYNC_DEPTH + STRETCH_CYC;

  logic released;
  logic safe;

  rst_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .arst_n   (rst_pin_n),
    .released (released)
  );

  rst_stretch_cnt #(.CYCLES(STRETCH_CYC)) u_cnt (
    .clk      (clk),
    .arst_n   (rst_pin_n),
    .released (released),
    .done_n   (core_rst_n)
  );

  assign safe = !core_rst_n || !drive_en;

  stream_safe_mux #(.W(LOC_N), .CW(LOC_CW)) u_loc (
    .safe     (safe),
    .strap_hi (loc_strap_hi),
    .data_in  (loc_data_in),
    .ctl_in   (loc_bufctl_in),
    .data_out (loc_out),
    .oe       (loc_oe),
    .ctl_out  (loc_bufctl)
  );

  stream_safe_mux #(.W(BP_N), .CW(BP_CW)) u_bp (
    .safe     (safe),
    .strap_hi (bp_strap_hi),
    .data_in  (bp_data_in),
    .ctl_in   (bp_bufctl_in),
    .data_out (bp_out),
    .oe       (bp_oe),
    .ctl_out  (bp_bufctl)
  );
endmodule

// File: rtl/rst_safe_chk.sv
`timescale 1ns/1ps
module rst_safe_chk #(
  parameter int LOC_N     = 16,
  parameter int BP_N      = 32,
  parameter int LOC_CW    = 2,
  parameter int BP_CW     = 4,
  parameter int REL_EDGES = 402
) (
  input logic              clk,
  input logic              rst_pin_n,
  input logic              drive_en,
  input logic              loc_strap_hi,
  input logic              bp_strap_hi,
  input logic [LOC_N-1:0]  loc_data_in,
  input logic [BP_N-1:0]   bp_data_in,
  input logic [LOC_CW-1:0] loc_bufctl_in,
  input logic [BP_CW-1:0]  bp_bufctl_in,
  input logic              core_rst_n,
  input logic [LOC_N-1:0]  loc_out,
  input logic [LOC_N-1:0]  loc_oe,
  input logic [BP_N-1:0]   bp_out,
  input logic [BP_N-1:0]   bp_oe,
  input logic [LOC_CW-1:0] loc_bufctl,
  input logic [BP_CW-1:0]  bp_bufctl
);
  // Edges seen since the pin last went high, saturating.
  logic [31:0] hi_edges;
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n)                 hi_edges <= '0;
    else if (hi_edges != 32'hFFFF_FFFF) hi_edges <= hi_edges + 1'b1;
  end

  // R1
  pin_holds_reset_chk: assert property (@(posedge clk)
    !rst_pin_n |-> !core_rst_n);

  // R2
  release_edge_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(core_rst_n) |-> (hi_edges == 32'(REL_EDGES)));

  // R5
  stays_released_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    core_rst_n |=> core_rst_n);

  // R7
  loc_safe_chk: assert property (@(posedge clk)
    (!core_rst_n || !drive_en) |->
      (loc_strap_hi ? (&loc_out && &loc_oe) : (loc_oe == '0 && loc_out == '0)));

  // R8
  bp_safe_chk: assert property (@(posedge clk)
    (!core_rst_n || !drive_en) |->
      (bp_strap_hi ? (&bp_out && &bp_oe) : (bp_oe == '0 && bp_out == '0)));

  // R9
  bufctl_quiet_chk: assert property (@(posedge clk)
    (!core_rst_n || !drive_en) |-> (loc_bufctl == '0 && bp_bufctl == '0));

  // R10
  pass_through_chk: assert property (@(posedge clk)
    (core_rst_n && drive_en) |->
      (loc_out == loc_data_in && bp_out == bp_data_in && &loc_oe && &bp_oe
       && loc_bufctl == loc_bufctl_in && bp_bufctl == bp_bufctl_in));
endmodule

bind rst_stretch_safe_ctl rst_safe_chk #(
  .LOC_N(LOC_N), .BP_N(BP_N), .LOC_CW(LOC_CW), .BP_CW(BP_CW),
  .REL_EDGES(REL_EDGES)
) u_chk (.*);

// File: tb/sim_rst_stretch_safe_ctl.sv
`timescale 1ns/1ps
module sim_rst_stretch_safe_ctl;
  localparam int LOC_N = 16, BP_N = 32, LOC_CW = 2, BP_CW = 4;
  localparam int SYNC_DEPTH = 2;
  localparam int STRETCH = (8000 * 50 + 999) / 1000;
  localparam int REL = SYNC_DEPTH + STRETCH;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_pin_n, drive_en, loc_strap_hi, bp_strap_hi;
  logic [LOC_N-1:0]  loc_data_in, loc_out, loc_oe;
  logic [BP_N-1:0]   bp_data_in, bp_out, bp_oe;
  logic [LOC_CW-1:0] loc_bufctl_in, loc_bufctl;
  logic [BP_CW-1:0]  bp_bufctl_in, bp_bufctl;
  logic core_rst_n;

  rst_stretch_safe_ctl u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .drive_en(drive_en),
    .loc_strap_hi(loc_strap_hi), .bp_strap_hi(bp_strap_hi),
    .loc_data_in(loc_data_in), .bp_data_in(bp_data_in),
    .loc_bufctl_in(loc_bufctl_in), .bp_bufctl_in(bp_bufctl_in),
    .core_rst_n(core_rst_n), .loc_out(loc_out), .loc_oe(loc_oe),
    .bp_out(bp_out), .bp_oe(bp_oe), .loc_bufctl(loc_bufctl), .bp_bufctl(bp_bufctl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] exp_val(bit safe, bit strap, logic [63:0] d, int w);
    if (!safe) return d & mask_of(w);
    return strap ? mask_of(w) : 64'd0;
  endfunction

  function automatic logic [63:0] exp_oe(bit safe, bit strap, int w);
    return (!safe || strap) ? mask_of(w) : 64'd0;
  endfunction

  task automatic check_outputs(string req, bit safe);
    chk(req, "loc_out", 64'(loc_out), exp_val(safe, loc_strap_hi, 64'(loc_data_in), LOC_N));
    chk(req, "loc_oe",  64'(loc_oe),  exp_oe(safe, loc_strap_hi, LOC_N));
    chk(req, "bp_out",  64'(bp_out),  exp_val(safe, bp_strap_hi, 64'(bp_data_in), BP_N));
    chk(req, "bp_oe",   64'(bp_oe),   exp_oe(safe, bp_strap_hi, BP_N));
    chk(req, "loc_bufctl", 64'(loc_bufctl), safe ? 64'd0 : 64'(loc_bufctl_in));
    chk(req, "bp_bufctl",  64'(bp_bufctl),  safe ? 64'd0 : 64'(bp_bufctl_in));
  endtask

  task automatic new_data();
    loc_data_in   = LOC_N'($urandom);
    bp_data_in    = BP_N'($urandom);
    loc_bufctl_in = LOC_CW'($urandom);
    bp_bufctl_in  = BP_CW'($urandom);
  endtask

  // Call right after the pin rises between edges; reports the first high edge.
  task automatic measure_release(string req);
    int first;
    first = 0;
    for (int k = 1; k <= REL + 4; k++) begin
      @(posedge clk); #1;
      if (core_rst_n === 1'b1 && first == 0) first = k;
    end
    chk(req, "release edge", 64'(first), 64'(REL));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    rst_pin_n = 1'b0; drive_en = 1'b1;
    loc_strap_hi = 1'b0; bp_strap_hi = 1'b0;
    new_data();

    // Reset state and strap combinations during reset
    repeat (3) @(posedge clk); #5;
    chk("R1", "core_rst_n held", 64'(core_rst_n), 64'd0);
    for (int i = 0; i < 4; i++) begin
      loc_strap_hi = i[0]; bp_strap_hi = i[1];
      drive_en = 1'b1; new_data(); #2;
      check_outputs("R6 R7 R8 R9", 1'b1);
    end

    // First release timing
    @(posedge clk); #5; rst_pin_n = 1'b1;
    measure_release("R2");

    // Random operation with drive_en toggling mid-cycle
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #5;
      drive_en = ($urandom % 4) != 0;
      loc_strap_hi = $urandom % 2; bp_strap_hi = $urandom % 2;
      new_data(); #2;
      check_outputs("R10 R11", !drive_en);
      chk("R5", "core_rst_n stays", 64'(core_rst_n), 64'd1);
    end

    // Asynchronous assertion between edges, then a two-edge pulse
    drive_en = 1'b1;
    @(posedge clk); #7; rst_pin_n = 1'b0; #1;
    chk("R1", "async assert", 64'(core_rst_n), 64'd0);
    check_outputs("R1 R6", 1'b1);
    repeat (2) @(posedge clk); #5; rst_pin_n = 1'b1;
    measure_release("R4");

    // Restart during the settling interval
    @(posedge clk); #5; rst_pin_n = 1'b0;
    repeat (3) @(posedge clk); #5; rst_pin_n = 1'b1;
    repeat (200) @(posedge clk); #5;
    chk("R3", "mid interval still reset", 64'(core_rst_n), 64'd0);
    new_data(); #1;
    check_outputs("R6", 1'b1);
    @(posedge clk); #5; rst_pin_n = 1'b0;
    repeat (2) @(posedge clk); #5; rst_pin_n = 1'b1;
    measure_release("R3");

    // Held release with varying inputs
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #5;
      drive_en = 1'b1; new_data(); #2;
      check_outputs("R10", 1'b0);
      chk("R5", "core_rst_n stays", 64'(core_rst_n), 64'd1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule